// File: doc/BRIEF.md
# Sized memory-cycle master for a 16-bit expansion bus

This block turns single requests from a local port into memory read and write cycles on a 16-bit expansion bus. Each request carries a 24-bit address, a write flag, a data word and two byte enables. Every bus cycle starts with one address clock. In that clock the address latch enable is high, the low address group is driven for receivers to latch, and the upper address group is driven unlatched. A command strobe follows, and one idle clock closes the cycle.

At the end of the first address clock the block samples the target's active-low 16-bit chip select. If the select is asserted, the access runs as one word cycle with one wait state. If it is not asserted, the target is byte-wide. A request with both byte enables set is then split into two byte cycles, even address first. Upper-byte data travels on the low data lane. Read bytes are reassembled into one word, and the requester sees a single completion pulse.

Top module: `isa_mem_master`

## Requirements
- R1: bale_o is high for exactly one clock at the start of every bus cycle, and a command strobe only goes low in the clock right after a bale_o clock, so the address is valid one full clock before the strobe.
- R2: The strobes are active low. A read uses memr_no and a write uses memw_no, and the two are never low at the same time.
- R3: From the bale_o clock to the end of the strobe, la_o carries address bits 23:17 and sa_o[19:1] carries address bits 19:1. sa_o[0] is 1 only for a high-byte cycle, which is an 8-bit odd cycle or a 16-bit cycle with byte enables 2'b10.
- R4: smemr_no and smemw_no copy memr_no and memw_no only when address bits 23:20 are zero. Otherwise they stay high.
- R5: memcs16_ni is sampled at the end of a request's first address clock. If it is low, the request runs as one 16-bit cycle whose strobe is low for 2 clocks.
- R6: If memcs16_ni is high and req_be_i is 2'b11, two byte cycles follow, low byte at the even address first. Each strobe is low for 4 clocks, and the strobe stays high for 2 clocks between the cycles (one idle clock, then the next address clock). memcs16_ni is ignored in the second cycle. If only one byte enable is set, a single byte cycle runs.
- R7: sbhe_no is low during a 16-bit cycle whose req_be_i[1] is set. It stays high during the strobe of every 8-bit cycle.
- R8: On writes, sd_oe_o is high only while the strobe is low. A 16-bit cycle drives the whole word, and a high-byte 8-bit cycle drives data bits 15:8 on sd_o[7:0]. On reads, sd_oe_o stays low.
- R9: A 16-bit read returns sd_i as sampled in the last strobe clock. A byte read takes sd_i[7:0] into the enabled byte of rsp_rdata_o, and unread bytes read as zero.
- R10: rsp_done_o is high for exactly one clock, in the idle clock after the final strobe. This is 4 clocks after acceptance for a word cycle, 6 for one byte cycle and 12 for a split. req_ready_o is high only when the block is idle.
- R11: While rst_ni is low, all strobes are high, bale_o is low, sd_oe_o is low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | 24 | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_done_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Read result, valid with rsp_done_o |
| bale_o | output | 1 | Address latch enable |
| sa_o | output | 20 | Latched low address group |
| la_o | output | 7 | Unlatched upper address bits 23:17 |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| smemr_no | output | 1 | Low-megabyte read strobe |
| smemw_no | output | 1 | Low-megabyte write strobe |
| sbhe_no | output | 1 | Upper-byte enable, active low |
| memcs16_ni | input | 1 | Target is 16-bit, active low |
| sd_i | input | 16 | Data bus in |
| sd_o | output | 16 | Data bus out |
| sd_oe_o | output | 1 | Data bus drive enable |

## Verification
Requests are run against a wide target and against a byte-wide target, as reads and writes, with each of the three byte-enable patterns. The word-versus-byte cases tell the strobe lengths and completion latencies apart. The split cases show the even-then-odd order, the lane steering and the reassembled read word. On the byte-wide target, chip select is pulled active for the second half of a split to show that it is sampled only once. Addresses above and below the first megabyte separate the qualified low-megabyte strobes from the plain ones. The byte-wide target puts junk on the upper lane to show that it never reaches the read result.

// File: rtl/isa_mem_pkg.sv
package isa_mem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_REC
  } phase_e;
endpackage

// File: rtl/isa_mem_seq.sv
module isa_mem_seq
  import isa_mem_pkg::*;
#(
  parameter int WAIT16 = 2,
  parameter int WAIT8  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] be_i,
  input  logic       cs16_ni,
  output phase_e     phase_o,
  output logic       byte_mode_o,
  output logic       hi_o,
  output logic       be_hi_o,
  output logic       cap_o,
  output logic       done_o
);
  localparam int MAXW = (WAIT8 > WAIT16) ? WAIT8 : WAIT16;
  localparam int CW   = $clog2(MAXW + 1);

  phase_e         phase_q;
  logic [CW-1:0]  cnt_q, limit;
  logic [1:0]     be_q;
  logic           byte_q, hi_q, first_q, more;

  assign limit = byte_q ? CW'(WAIT8 - 1) : CW'(WAIT16 - 1);
  // second byte still owed on a split access
  assign more  = byte_q & (be_q == 2'b11) & ~hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      be_q    <= '0;
      byte_q  <= 1'b0;
      hi_q    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      case (phase_q)
        ST_IDLE: if (start_i) begin
          phase_q <= ST_ADDR;
          be_q    <= be_i;
          byte_q  <= 1'b0;
          hi_q    <= (be_i == 2'b10);
          first_q <= 1'b1;
        end
        ST_ADDR: begin
          phase_q <= ST_CMD;
          cnt_q   <= '0;
          first_q <= 1'b0;
          if (first_q) byte_q <= cs16_ni;
        end
        ST_CMD: begin
          if (cnt_q == limit) phase_q <= ST_REC;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (more) begin
            phase_q <= ST_ADDR;
            hi_q    <= 1'b1;
          end else begin
            phase_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign byte_mode_o = byte_q;
  assign hi_o        = hi_q;
  assign be_hi_o     = be_q[1];
  assign cap_o       = (phase_q == ST_CMD) && (cnt_q == limit);
  assign done_o      = (phase_q == ST_REC) && !more;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_CMD) |-> (cnt_q <= limit)); // R5
  AST_SPLIT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_REC && more) |=> (phase_q == ST_ADDR && hi_q)); // R6
endmodule

// File: rtl/isa_mem_lane.sv
module isa_mem_lane #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          byte_mode_i,
  input  logic          hi_i,
  input  logic          cap_i,
  input  logic [DW-1:0] sd_i,
  output logic [DW-1:0] sd_o,
  output logic [DW-1:0] rdata_o
);
  localparam int BW = DW / 2;

  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (cap_i && !we_i) begin
      if (!byte_mode_i)  rdata_q          <= sd_i;
      else if (hi_i)     rdata_q[DW-1:BW] <= sd_i[BW-1:0];
      else               rdata_q[BW-1:0]  <= sd_i[BW-1:0];
    end
  end

  // byte targets see the upper byte on the low lane
  always_comb begin
    sd_o = wdata_q;
    if (byte_mode_i && hi_i) sd_o[BW-1:0] = wdata_q[DW-1:BW];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/isa_mem_master.sv
module isa_mem_master
  import isa_mem_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int SAW    = 20,
  parameter int LA_LSB = 17,
  parameter int WAIT16 = 2,
  parameter int WAIT8  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              req_we_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [1:0]        req_be_i,
  output logic              rsp_done_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              bale_o,
  output logic [SAW-1:0]    sa_o,
  output logic [AW-1:LA_LSB] la_o,
  output logic              memr_no,
  output logic              memw_no,
  output logic              smemr_no,
  output logic              smemw_no,
  output logic              sbhe_no,
  input  logic              memcs16_ni,
  input  logic [DW-1:0]     sd_i,
  output logic [DW-1:0]     sd_o,
  output logic              sd_oe_o
);
  phase_e        phase;
  logic [AW-1:1] addr_q;
  logic          we_q, byte_mode, hi, be_hi, cap, done, start, strb, low_mb;

  assign req_ready_o = (phase == ST_IDLE);
  assign start       = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      we_q   <= 1'b0;
    end else if (start) begin
      addr_q <= req_addr_i[AW-1:1];
      we_q   <= req_we_i;
    end
  end

  isa_mem_seq #(.WAIT16(WAIT16), .WAIT8(WAIT8)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .be_i       (req_be_i),
    .cs16_ni    (memcs16_ni),
    .phase_o    (phase),
    .byte_mode_o(byte_mode),
    .hi_o       (hi),
    .be_hi_o    (be_hi),
    .cap_o      (cap),
    .done_o     (done)
  );

  isa_mem_lane #(.DW(DW)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wdata_i    (req_wdata_i),
    .we_i       (we_q),
    .byte_mode_i(byte_mode),
    .hi_i       (hi),
    .cap_i      (cap),
    .sd_i       (sd_i),
    .sd_o       (sd_o),
    .rdata_o    (rsp_rdata_o)
  );

  assign strb     = (phase == ST_CMD);
  assign low_mb   = ~|addr_q[AW-1:SAW];
  assign bale_o   = (phase == ST_ADDR);
  assign sa_o     = {addr_q[SAW-1:1], hi};
  assign la_o     = addr_q[AW-1:LA_LSB];
  assign memr_no  = ~(strb & ~we_q);
  assign memw_no  = ~(strb & we_q);
  assign smemr_no = ~(strb & ~we_q & low_mb);
  assign smemw_no = ~(strb & we_q & low_mb);
  assign sbhe_no  = ~((phase != ST_IDLE) & be_hi & ~byte_mode);
  assign sd_oe_o  = strb & we_q;
  assign rsp_done_o = done;

  AST_SETUP_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(memr_no) || $fell(memw_no)) |-> $past(bale_o)); // R1
  AST_BALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bale_o |=> !bale_o); // R1
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!memr_no && !memw_no)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!memr_no || !memw_no) |-> ($stable(sa_o) && $stable(la_o))); // R3
  AST_LOW_MB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smemr_no || !smemw_no) |-> (la_o[AW-1:SAW] == '0 && (!memr_no || !memw_no))); // R4
  AST_READ_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !memr_no |-> !sd_oe_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> (req_ready_o && !rsp_done_o)); // R10
endmodule

// File: tb/isa_mem_master_test.sv
`timescale 1ns/1ps
module isa_mem_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        bale, memr_n, memw_n, smemr_n, smemw_n, sbhe_n, memcs16_n, sd_oe;
  logic [19:0] sa;
  logic [23:17] la;
  logic [15:0] sd_in, sd_out;

  int total = 0, bad = 0;
  bit tb_wide = 1'b0;
  logic [15:0] tgt = '0;
  int ncyc = 0, gap = 0, len = 0;
  bit in_cyc = 0, prev_bale = 0;
  int c_len[4], c_gap[4];
  logic [19:0] c_sa[4];
  logic [6:0] c_la[4];
  logic [15:0] c_sd[4];
  bit c_oe[4], c_sbhe[4], c_smem[4], c_wr[4], c_bale[4];
  logic [16:0] exp_q[$];

  always #4 clk = ~clk;

  isa_mem_master uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata), .bale_o(bale), .sa_o(sa), .la_o(la),
    .memr_no(memr_n), .memw_no(memw_n), .smemr_no(smemr_n), .smemw_no(smemw_n),
    .sbhe_no(sbhe_n), .memcs16_ni(memcs16_n), .sd_i(sd_in), .sd_o(sd_out), .sd_oe_o(sd_oe)
  );

  // target model: chip select honest only on the first cycle
  assign memcs16_n = (ncyc == 0) ? ~tb_wide : tb_wide;
  assign sd_in = tb_wide ? tgt : {8'hA5, sa[0] ? tgt[15:8] : tgt[7:0]};

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus recorder
  always @(negedge clk) begin
    if (rst_n) begin
      if (!memr_n || !memw_n) begin
        if (!in_cyc) begin
          in_cyc = 1; len = 0;
          if (ncyc < 4) begin
            c_bale[ncyc] = prev_bale; c_sa[ncyc] = sa; c_la[ncyc] = la; c_gap[ncyc] = gap;
          end
        end
        len++;
        if (ncyc < 4) begin
          c_sd[ncyc] = sd_out; c_oe[ncyc] = sd_oe; c_sbhe[ncyc] = sbhe_n;
          c_smem[ncyc] = !smemr_n || !smemw_n; c_wr[ncyc] = !memw_n;
        end
        gap = 0;
      end else begin
        if (in_cyc) begin
          in_cyc = 0;
          if (ncyc < 4) c_len[ncyc] = len;
          ncyc++;
        end
        gap++;
      end
      prev_bale = bale;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) check(0, "R10", 1, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if (e[16]) check(rsp_rdata == e[15:0], "R9", rsp_rdata, e[15:0]);
      end
    end
  end

  task automatic run(logic [23:0] a, bit w, logic [15:0] wd, logic [1:0] be, bit wide, logic [15:0] tw);
    int n, k, exp_lat;
    bit hi0;
    logic [15:0] er;
    bit low_mb;
    low_mb = (a[23:20] == 4'h0);
    hi0 = (be == 2'b10);
    n = (!wide && be == 2'b11) ? 2 : 1;
    exp_lat = wide ? 4 : (n == 2 ? 12 : 6);
    er = wide ? tw : {be[1] ? tw[15:8] : 8'h00, (be[0] || be == 2'b00) ? tw[7:0] : 8'h00};
    exp_q.push_back({!w, er});
    @(negedge clk);
    tb_wide = wide; tgt = tw; ncyc = 0;
    req_addr = a; req_we = w; req_wdata = wd; req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!rsp_done && k < 40) begin
      @(negedge clk); k++;
    end
    check(k == exp_lat, "R10", k, exp_lat);
    @(negedge clk);
    check(!rsp_done, "R10", rsp_done, 0);
    check(ncyc == n, "R6", ncyc, n);
    for (int i = 0; i < n && i < 4; i++) begin
      bit hi;
      hi = (n == 2) ? (i == 1) : hi0;
      check(c_len[i] == (wide ? 2 : 4), wide ? "R5" : "R6", c_len[i], wide ? 2 : 4);
      check(c_bale[i], "R1", c_bale[i], 1);
      check(c_sa[i] == {a[19:1], hi}, "R3", c_sa[i], {a[19:1], hi});
      check(c_la[i] == a[23:17], "R3", c_la[i], a[23:17]);
      check(c_sbhe[i] == (wide ? ~be[1] : 1'b1), "R7", c_sbhe[i], wide ? ~be[1] : 1'b1);
      check(c_smem[i] == low_mb, "R4", c_smem[i], low_mb);
      check(c_wr[i] == w, "R2", c_wr[i], w);
      check(c_oe[i] == w, "R8", c_oe[i], w);
      if (w) begin
        if (wide) check(c_sd[i] == wd, "R8", c_sd[i], wd);
        else check(c_sd[i][7:0] == (hi ? wd[15:8] : wd[7:0]), "R8", c_sd[i][7:0], hi ? wd[15:8] : wd[7:0]);
      end
      if (i == 1) check(c_gap[i] == 2, "R6", c_gap[i], 2);
    end
    check(req_ready, "R10", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(memr_n && memw_n && smemr_n && smemw_n, "R11", {memr_n, memw_n, smemr_n, smemw_n}, 4'hf);
    check(!bale, "R11", bale, 0);
    check(!sd_oe, "R11", sd_oe, 0);
    check(req_ready, "R11", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!rsp_done && memr_n && memw_n, "R11", rsp_done, 0);

    run(24'h012344, 1, 16'hC0DE, 2'b11, 1, 16'h0000);
    run(24'h3A0010, 0, 16'h0000, 2'b11, 1, 16'hBEEF);
    run(24'h0F1000, 1, 16'hA1B2, 2'b11, 0, 16'h0000);
    run(24'h234566, 0, 16'h0000, 2'b11, 0, 16'h1234);
    run(24'h000AB0, 0, 16'h0000, 2'b10, 0, 16'h5678);
    run(24'h500200, 1, 16'h9A3C, 2'b01, 0, 16'h0000);
    run(24'h07FFFE, 1, 16'h4D2E, 2'b10, 1, 16'h0000);
    run(24'hFF0002, 0, 16'h0000, 2'b01, 1, 16'h6E6F);
    run(24'h000100, 0, 16'h0000, 2'b11, 0, 16'hCAFE);
    run(24'h10FFFE, 1, 16'h7788, 2'b10, 0, 16'h0000);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule